// File: doc/BRIEF.md
# Dual-Rail Word Receiver with Completion Detection

This block takes in a word sent over a delay-insensitive channel. Each bit of the word travels on a pair of wires, so an N-bit word uses 2N wires. A pair with both wires low carries no data. A pair with exactly one wire high carries one bit value. Each bit therefore shows on its own wires when it has arrived. The block decodes every pair and merges the per-bit arrival flags through a tree of hold-state gates. Each gate goes high only when all of its inputs are high, goes low only when all of its inputs are low, and otherwise keeps its value. The root of the tree is the acknowledge sent back to the sender.

The block is a clocked, synthesizable model of the four-phase return-to-spacer protocol:

1. The sender drives a full valid word.
2. The acknowledge rises.
3. The sender returns every pair to the spacer.
4. The acknowledge falls.

On the clocked side, the decoded word appears together with a one-cycle done pulse. A sticky error flag records illegal pairs (both wires high). It also records pairs that take a new data code while the acknowledge is high.

Top module: `dr_word_rx`

## Requirements
- R1: For bit i, the pair (rail_one[i], rail_zero[i]) encodes 00 as spacer, 01 as logic 0 and 10 as logic 1. A word accepted at an acknowledge rise presents bit i on word_out[i].
- R2: Suppose every bit holds a valid code (01 or 10) at rising edge e. If ack was low, it is high after edge e+1 and not before. Likewise, if every bit is spacer at edge e, ack is low after edge e+1.
- R3: While at least one bit is spacer or illegal, a low ack stays low, however long the other bits have been valid.
- R4: While at least one bit still holds a valid code, a high ack stays high, even after the other bits have returned to spacer.
- R5: A pair of 11 is illegal and never counts as valid. If it is seen at an edge, proto_err is high after that edge.
- R6: done is high for exactly the one cycle in which ack first reads high. word_out changes only in that cycle and holds its value at all other times.
- R7: While ack is high, a bit whose code changes to anything other than spacer sets proto_err at the next edge.
- R8: Once proto_err is high, it stays high until reset.
- R9: While rst_n is low at a rising edge, ack, done, proto_err and word_out are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_one | input | WIDTH | Per-bit wire that goes high to carry a 1 |
| rail_zero | input | WIDTH | Per-bit wire that goes high to carry a 0 |
| ack | output | 1 | Acknowledge to the sender (completion tree root) |
| done | output | 1 | One-cycle pulse when a word is accepted |
| word_out | output | WIDTH | Last accepted word |
| proto_err | output | 1 | Sticky flag for illegal codes and protocol breaches |

## Verification
ack, done and word_out respond two rising edges after the input condition that causes them, because the path passes through a leaf register and then the root register. proto_err responds on the first edge after the offending input is sampled. The bench drives the rails just after each falling edge and steps a behavioural model at each rising edge. The model keeps a one-edge history of the conditions "all bits valid" and "all bits spacer". The bench compares every output against the model at the following falling edge, so each expected value is due exactly where these latencies put it. Directed checks then confirm the latencies, the partial-word and partial-return holds, and the error cases at those same cycles.

// File: rtl/dr_rx_pkg.sv
// Package: shared code values for the dual-rail receiver.
// The two-bit code of a pair is {rail_one, rail_zero}.
package dr_rx_pkg;

    typedef enum logic [1:0] {
        DR_SPACER = 2'b00,
        DR_ZERO   = 2'b01,
        DR_ONE    = 2'b10,
        DR_CLASH  = 2'b11
    } dr_code_e;

    // Pack the two wires of one bit into a code value.
    function automatic dr_code_e dr_pack(input logic one_w, input logic zero_w);
        return dr_code_e'({one_w, zero_w});
    endfunction

endpackage

// File: rtl/dr_rail_decode.sv
// Module: dr_rail_decode
// Decodes one wire pair into a code, a validity flag, an illegal flag and
// the bit value. Purely combinational. Assumes a monotonic sender, so no
// filtering is done here.
module dr_rail_decode
    import dr_rx_pkg::*;
(
    input  logic       one_w,
    input  logic       zero_w,
    output logic [1:0] code,
    output logic       is_valid,
    output logic       is_clash,
    output logic       value
);

    dr_code_e kind;

    // Classify the pair and derive the flags from its code.
    always_comb begin
        kind     = dr_pack(one_w, zero_w);
        code     = kind;
        is_valid = (kind == DR_ZERO) || (kind == DR_ONE);
        is_clash = (kind == DR_CLASH);
        value    = (kind == DR_ONE);
    end

endmodule

// File: rtl/dr_hold_gate.sv
// Module: dr_hold_gate
// Clocked hold-state gate. The output is set when every input is 1,
// cleared when every input is 0, and kept otherwise. Assumes its inputs
// are stable around the clock edge.
module dr_hold_gate #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_vec,
    output logic         q
);

    // Update the held state from the agreement of all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= 1'b0;
        else if (&in_vec)    q <= 1'b1;
        else if (!(|in_vec)) q <= 1'b0;
    end

    AST_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(&in_vec)); // R2

    AST_HOLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> $past(in_vec == '0)); // R4

endmodule

// File: rtl/dr_completion_tree.sv
// Module: dr_completion_tree
// Two-level completion tree made of hold-state gates. Leaf gates each take
// FANIN bit flags. A short last group repeats its first flag into the
// spare inputs. A root gate merges the leaves. Besides the root output,
// the module gives the root's value for the next edge, so that the parent
// can act in the same cycle the root changes.
module dr_completion_tree #(
    parameter int WIDTH = 8,
    parameter int FANIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bit_ok,
    output logic             complete,
    output logic             complete_nxt
);

    localparam int NGRP = (WIDTH + FANIN - 1) / FANIN;

    logic [NGRP-1:0][FANIN-1:0] leaf_in;
    logic [NGRP-1:0]            leaf_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_leaf
        for (genvar k = 0; k < FANIN; k++) begin : g_in
            localparam int IDX = g * FANIN + k;
            if (IDX < WIDTH) begin : g_real
                assign leaf_in[g][k] = bit_ok[IDX];
            end else begin : g_pad
                assign leaf_in[g][k] = bit_ok[g * FANIN];
            end
        end
        dr_hold_gate #(.N(FANIN)) u_leaf (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vec (leaf_in[g]),
            .q      (leaf_q[g])
        );
    end

    dr_hold_gate #(.N(NGRP)) u_root (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vec (leaf_q),
        .q      (complete)
    );

    // Root state after the coming edge: full agreement, or hold if any leaf is high.
    assign complete_nxt = (&leaf_q) | (complete & (|leaf_q));

endmodule

// File: rtl/dr_word_rx.sv
// Module: dr_word_rx
// Receives a WIDTH-bit word over dual-rail pairs and acknowledges it
// through a hold-state completion tree. On the edge where the acknowledge
// rises, it latches the decoded word and emits a one-cycle done pulse.
// A sticky error records illegal pairs, and pairs that take a new data
// code while the acknowledge is high. Assumes rails change only just after
// a clock edge, as modelled by the sending environment.
module dr_word_rx
    import dr_rx_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int FANIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_one,
    input  logic [WIDTH-1:0] rail_zero,
    output logic             ack,
    output logic             done,
    output logic [WIDTH-1:0] word_out,
    output logic             proto_err
);

    logic [WIDTH-1:0][1:0] code_now;
    logic [WIDTH-1:0][1:0] code_prev;
    logic [WIDTH-1:0]      bit_ok;
    logic [WIDTH-1:0]      bit_clash;
    logic [WIDTH-1:0]      bit_val;
    logic [WIDTH-1:0]      bit_bad;
    logic                  ack_nxt;
    logic                  accept;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dr_rail_decode u_dec (
            .one_w    (rail_one[i]),
            .zero_w   (rail_zero[i]),
            .code     (code_now[i]),
            .is_valid (bit_ok[i]),
            .is_clash (bit_clash[i]),
            .value    (bit_val[i])
        );
        // Flag a bit that takes a fresh data code while acknowledged.
        assign bit_bad[i] = ack && (code_now[i] != code_prev[i])
                                && (code_now[i] != DR_SPACER);
    end

    dr_completion_tree #(.WIDTH(WIDTH), .FANIN(FANIN)) u_tree (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_ok       (bit_ok),
        .complete     (ack),
        .complete_nxt (ack_nxt)
    );

    assign accept = ack_nxt & ~ack;

    // Remember each pair's code from the last edge for breach detection.
    always_ff @(posedge clk) begin
        if (!rst_n) code_prev <= '0;
        else        code_prev <= code_now;
    end

    // Latch the word and pulse done on the edge the acknowledge rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            word_out <= '0;
        end else begin
            done <= accept;
            if (accept) word_out <= bit_val;
        end
    end

    // Accumulate illegal codes and protocol breaches into the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= proto_err | (|bit_clash) | (|bit_bad);
    end

    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ack && !$past(ack))); // R6

    AST_WORD_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(word_out)); // R6

    AST_CLASH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (|bit_clash) |=> proto_err); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R8

endmodule

// File: tb/dr_word_rx_test.sv
// Bench for dr_word_rx. A behavioural model is stepped at each rising edge
// and compared with the outputs at the next falling edge. Directed checks
// cover each requirement.
module dr_word_rx_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] rail_one = '0;
    logic [W-1:0] rail_zero = '0;
    logic         ack, done, proto_err;
    logic [W-1:0] word_out;

    int checks = 0;
    int failures = 0;

    // Model state
    logic         m_ack = 0, m_done = 0, m_err = 0;
    logic [W-1:0] m_word = '0;
    logic         pv = 0, ps = 0;
    logic [1:0]   pc [W];

    always #4 clk = ~clk;

    dr_word_rx #(.WIDTH(W), .FANIN(3)) uut (
        .clk(clk), .rst_n(rst_n), .rail_one(rail_one), .rail_zero(rail_zero),
        .ack(ack), .done(done), .word_out(word_out), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit all_v, all_s, clash, viol, nack;
        logic [1:0] c;
        if (!rst_n) begin
            m_ack = 0; m_done = 0; m_err = 0; m_word = '0; pv = 0; ps = 0;
            for (int i = 0; i < W; i++) pc[i] = 2'b00;
            return;
        end
        all_v = 1; all_s = 1; clash = 0; viol = 0;
        for (int i = 0; i < W; i++) begin
            c = {rail_one[i], rail_zero[i]};
            if (!(c == 2'b01 || c == 2'b10)) all_v = 0;
            if (c != 2'b00) all_s = 0;
            if (c == 2'b11) clash = 1;
            if (m_ack && c != pc[i] && c != 2'b00) viol = 1;
            pc[i] = c;
        end
        m_err = m_err | clash | viol;
        nack = pv ? 1'b1 : (ps ? 1'b0 : m_ack);
        m_done = nack & ~m_ack;
        if (m_done) m_word = rail_one;
        m_ack = nack;
        pv = all_v; ps = all_s;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(ack == m_ack, "R2 ack vs model", ack, m_ack);
        chk(done == m_done, "R6 done vs model", done, m_done);
        chk(proto_err == m_err, "R5 err vs model", proto_err, m_err);
        chk(word_out == m_word, "R1 word vs model", word_out, m_word);
    endtask

    task automatic drive_word(input logic [W-1:0] v);
        rail_one = v; rail_zero = ~v;
    endtask

    task automatic drive_spacer();
        rail_one = '0; rail_zero = '0;
    endtask

    task automatic do_reset();
        rst_n = 0; drive_spacer();
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic handshake(input logic [W-1:0] v);
        drive_word(v);
        tick();
        tick();
        chk(ack === 1'b1 && done === 1'b1, "R2 ack with done", {ack, done}, 2'b11);
        chk(word_out === v, "R1 accepted word", word_out, v);
        drive_spacer();
        tick();
        tick();
        chk(ack === 1'b0, "R2 ack low after spacer", ack, 0);
    endtask

    initial begin : main
        do_reset();
        chk(ack === 0 && done === 0 && proto_err === 0, "R9 reset flags",
            {ack, done, proto_err}, 0);
        chk(word_out === '0, "R9 reset word", word_out, 0);
        tick();

        // Latency and pulse width
        drive_word(8'hA5);
        tick();
        chk(ack === 1'b0, "R2 ack not yet after one edge", ack, 0);
        tick();
        chk(ack === 1'b1, "R2 ack after second edge", ack, 1);
        chk(done === 1'b1, "R6 done with rise", done, 1);
        chk(word_out === 8'hA5, "R1 word A5", word_out, 8'hA5);
        tick();
        chk(done === 1'b0, "R6 done one cycle", done, 0);
        chk(word_out === 8'hA5, "R6 word held", word_out, 8'hA5);
        drive_spacer();
        tick();
        chk(ack === 1'b1, "R2 ack still high one edge after spacer", ack, 1);
        tick();
        chk(ack === 1'b0, "R2 ack low two edges after spacer", ack, 0);

        // Partial word keeps ack low
        rail_one = 8'h0C; rail_zero = 8'h03;
        repeat (4) tick();
        chk(ack === 1'b0, "R3 partial word", ack, 0);
        drive_word(8'h3C);
        tick(); tick();
        chk(ack === 1'b1 && word_out === 8'h3C, "R3 completes", {ack, word_out}, {1'b1, 8'h3C});
        // Partial return keeps ack high
        rail_one = 8'h30; rail_zero = 8'hC0;
        repeat (4) tick();
        chk(ack === 1'b1, "R4 partial return", ack, 1);
        chk(proto_err === 1'b0, "R7 return is legal", proto_err, 0);
        drive_spacer();
        tick(); tick();
        chk(ack === 1'b0, "R4 full return", ack, 0);

        handshake(8'h00);
        handshake(8'hFF);
        handshake(8'h5A);
        handshake(8'h81);

        // Illegal pair
        drive_word(8'h12);
        rail_one[3] = 1'b1; rail_zero[3] = 1'b1;
        tick();
        chk(proto_err === 1'b1, "R5 clash sets error", proto_err, 1);
        repeat (3) tick();
        chk(ack === 1'b0, "R5 clash not valid", ack, 0);
        chk(word_out === 8'h81, "R5 word untouched", word_out, 8'h81);
        drive_spacer();
        repeat (3) tick();
        chk(proto_err === 1'b1, "R8 sticky after clash", proto_err, 1);
        do_reset();
        chk(proto_err === 1'b0 && ack === 1'b0, "R9 reset clears error", {proto_err, ack}, 0);
        tick();

        // Code change while acknowledged
        drive_word(8'h0F);
        tick(); tick();
        chk(proto_err === 1'b0, "R7 no error before breach", proto_err, 0);
        rail_one[0] = 1'b0; rail_zero[0] = 1'b1;
        tick();
        chk(proto_err === 1'b1, "R7 breach sets error", proto_err, 1);
        drive_spacer();
        repeat (4) tick();
        chk(proto_err === 1'b1, "R8 error held", proto_err, 1);
        do_reset();
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule